// File: doc/BRIEF.md
# SPI Daisy-Chain Host Sequencer

This block is the host side of a serial link that reaches several chained potentiometer devices through one chip select, one serial clock, one data-out and one data-in line. Each device's output feeds the next device's input, so every frame has to carry one two-byte unit for every device in the chain. The caller hands over one request vector holding a command for every device: write a byte to an address, read an address, or stay idle. The block turns that vector into frames, generates the serial clock from the system clock, and reports the outcome per device.

A frame is sent with the unit for the device farthest from the host first, so that after all bits have been shifted each device holds its own unit. All writes in a frame take effect together when chip select rises. When any device is asked for a read, a second frame of all-zero no-operation units follows. During that frame the answers travel out of the chain. The block maps them back to device indices, checks every answer's header byte, and returns the data byte with a valid or an error flag.

The chain length, the serial clock divider and the minimum deselect time are parameters.

Top module: `dch_chain_host`

## Requirements
- R1: A frame holds exactly 16*N_DEV rising edges of `spi_sck` between the fall and the rise of `spi_cs_n`. `spi_sck` is low whenever `spi_cs_n` is high. Each half period of `spi_sck` lasts HALF_DIV clock cycles.
- R2: The unit for device N_DEV-1 is shifted out first and the unit for device 0 is shifted out last. Each unit is sent MSB first, with its command byte ahead of its data byte. The command byte is {code[2:0], addr[4:0]}. The code is 3'b010 for a write and 3'b001 for a read. A write unit carries the write byte. A read unit carries 8'h00. An idle device gets 16'h0000.
- R3: A request with no read command produces exactly one frame. Its writes are committed by the devices at the rise of `spi_cs_n` that ends it.
- R4: A request with at least one read command produces a second frame made of N_DEV all-zero units.
- R5: In the second frame, the first 16 bits received on `spi_miso` belong to device N_DEV-1 and the last 16 bits belong to device 0. The second byte of each device's 16 bits is returned on `rd_data[8*k +: 8]`.
- R6: For a device that was read, `rd_valid[k]`=1 and `rd_err[k]`=0 when its first returned byte equals {3'b111, addr}. Otherwise `rd_err[k]`=1 and `rd_valid[k]`=0. For a device that was not read, both flags are 0 and its `rd_data` byte is 0. The two flags are never high together.
- R7: `busy` rises in the cycle after `req_valid` is accepted. It stays high until the last `spi_cs_n` rise of the request. `req_valid` is ignored while `busy` is high, and such a request sends no frame and changes no device.
- R8: Between any two frames, `spi_cs_n` stays high for at least 2*GAP_SCK*HALF_DIV clock cycles.
- R9: `done` pulses for one cycle at the last `spi_cs_n` rise, in the same cycle `busy` falls. `rd_valid`, `rd_err` and `rd_data` change only in that cycle.
- R10: After reset, `spi_cs_n`=1, `spi_sck`=0, `spi_mosi`=0, `busy`=0, `done`=0, `rd_valid`=0 and `rd_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2*N_DEV | Per-device command: 00 idle, 01 write, 10 read, 11 idle |
| req_addr | input | 5*N_DEV | Per-device register address |
| req_wdata | input | 8*N_DEV | Per-device write byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | N_DEV | Read answer accepted, per device |
| rd_err | output | N_DEV | Read answer header mismatch, per device |
| rd_data | output | 8*N_DEV | Returned data byte, per device |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to device 0 |
| spi_miso | input | 1 | Serial data from device N_DEV-1 |

## Verification
The assertions check on every cycle the properties that need no knowledge of device contents. These are the edge count per frame, a low clock while deselected, the deselect gap, chip select activity only while busy, the done/busy relation, the exclusive flags, and results that hold between completions. Only the bench's scenarios can show unit order and encoding, the mapping of answers back to devices, the value of returned data after earlier writes, detection of a corrupted header, and that a request raised while busy leaves the devices untouched. For those, the bench runs a shift-chain device model with register storage.

// File: rtl/dch_pkg.sv
package dch_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int UNIT_W = 16;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } dev_op_e;

    localparam logic [2:0] CODE_WRITE = 3'b010;
    localparam logic [2:0] CODE_READ  = 3'b001;
    localparam logic [2:0] CODE_HDR   = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WAIT  = 2'b01,
        ST_SHIFT = 2'b10
    } seq_state_e;

endpackage

// File: rtl/dch_sck_div.sv
module dch_sck_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CW'(HALF_DIV - 1)) && !clr;

    always_comb begin
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dch_frame_build.sv
module dch_frame_build
    import dch_pkg::*;
#(
    parameter int N_DEV = 3
) (
    input  logic [2*N_DEV-1:0]      op,
    input  logic [ADDR_W*N_DEV-1:0] addr,
    input  logic [DATA_W*N_DEV-1:0] wdata,
    input  logic                    nop_frame,
    output logic [UNIT_W*N_DEV-1:0] frame
);
    // Device g sits in slice g; the top slice (device N_DEV-1) leaves first.
    for (genvar g = 0; g < N_DEV; g++) begin : g_unit
        logic [UNIT_W-1:0] unit;
        always_comb begin
            unit = '0;
            if (!nop_frame) begin
                case (dev_op_e'(op[2*g +: 2]))
                    OP_WRITE: unit = {CODE_WRITE, addr[ADDR_W*g +: ADDR_W], wdata[DATA_W*g +: DATA_W]};
                    OP_READ:  unit = {CODE_READ,  addr[ADDR_W*g +: ADDR_W], {DATA_W{1'b0}}};
                    default:  unit = '0;
                endcase
            end
        end
        assign frame[UNIT_W*g +: UNIT_W] = unit;
    end
endmodule

// File: rtl/dch_resp_check.sv
module dch_resp_check
    import dch_pkg::*;
#(
    parameter int N_DEV = 3
) (
    input  logic [UNIT_W*N_DEV-1:0] rx,
    input  logic [2*N_DEV-1:0]      op,
    input  logic [ADDR_W*N_DEV-1:0] addr,
    output logic [N_DEV-1:0]        vld,
    output logic [N_DEV-1:0]        err,
    output logic [DATA_W*N_DEV-1:0] data
);
    // The first 16 bits received land in the top slice, i.e. device N_DEV-1.
    for (genvar g = 0; g < N_DEV; g++) begin : g_chk
        logic       is_rd;
        logic       hdr_ok;
        logic [7:0] hdr;
        assign hdr    = rx[UNIT_W*g + DATA_W +: 8];
        assign is_rd  = (dev_op_e'(op[2*g +: 2]) == OP_READ);
        assign hdr_ok = (hdr == {CODE_HDR, addr[ADDR_W*g +: ADDR_W]});
        assign vld[g] = is_rd && hdr_ok;
        assign err[g] = is_rd && !hdr_ok;
        assign data[DATA_W*g +: DATA_W] = is_rd ? rx[UNIT_W*g +: DATA_W] : '0;
    end
endmodule

// File: rtl/dch_chain_host.sv
module dch_chain_host
    import dch_pkg::*;
#(
    parameter int N_DEV    = 3,
    parameter int HALF_DIV = 2,
    parameter int GAP_SCK  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [2*N_DEV-1:0]      req_op,
    input  logic [ADDR_W*N_DEV-1:0] req_addr,
    input  logic [DATA_W*N_DEV-1:0] req_wdata,
    output logic                    busy,
    output logic                    done,
    output logic [N_DEV-1:0]        rd_valid,
    output logic [N_DEV-1:0]        rd_err,
    output logic [DATA_W*N_DEV-1:0] rd_data,
    output logic                    spi_cs_n,
    output logic                    spi_sck,
    output logic                    spi_mosi,
    input  logic                    spi_miso
);
    localparam int FRAME_W   = UNIT_W * N_DEV;
    localparam int CNT_W     = $clog2(FRAME_W);
    localparam int GAP_TICKS = 2 * GAP_SCK;
    localparam int GAP_W     = $clog2(GAP_TICKS + 1);
    localparam int OP_W      = 2 * N_DEV;
    localparam int AD_W      = ADDR_W * N_DEV;
    localparam int WD_W      = DATA_W * N_DEV;

    typedef struct packed {
        seq_state_e         st;
        logic               phase;
        logic               any_rd;
        logic [OP_W-1:0]    op;
        logic [AD_W-1:0]    addr;
        logic [WD_W-1:0]    wdata;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        logic [CNT_W-1:0]   bit_cnt;
        logic [GAP_W-1:0]   gap;
        logic               sck;
        logic               cs_n;
        logic               busy;
        logic               done;
        logic [N_DEV-1:0]   vld;
        logic [N_DEV-1:0]   err;
        logic [WD_W-1:0]    data;
    } seq_t;

    seq_t s_d, s_q;

    logic               tick;
    logic               div_clr;
    logic               req_any_rd;
    logic [FRAME_W-1:0] frame_word;
    logic [N_DEV-1:0]   chk_vld;
    logic [N_DEV-1:0]   chk_err;
    logic [WD_W-1:0]    chk_data;

    dch_sck_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .tick  (tick)
    );

    dch_frame_build #(.N_DEV(N_DEV)) u_build (
        .op        (s_q.op),
        .addr      (s_q.addr),
        .wdata     (s_q.wdata),
        .nop_frame (s_q.phase),
        .frame     (frame_word)
    );

    dch_resp_check #(.N_DEV(N_DEV)) u_resp (
        .rx   (s_q.rx),
        .op   (s_q.op),
        .addr (s_q.addr),
        .vld  (chk_vld),
        .err  (chk_err),
        .data (chk_data)
    );

    always_comb begin
        req_any_rd = 1'b0;
        for (int i = 0; i < N_DEV; i++) begin
            if (dev_op_e'(req_op[2*i +: 2]) == OP_READ) req_any_rd = 1'b1;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        div_clr  = 1'b0;

        // Deselect time is measured in half periods while chip select is high.
        if (s_q.cs_n && tick && (s_q.gap != GAP_W'(GAP_TICKS)))
            s_d.gap = s_q.gap + 1'b1;

        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.op     = req_op;
                    s_d.addr   = req_addr;
                    s_d.wdata  = req_wdata;
                    s_d.any_rd = req_any_rd;
                    s_d.phase  = 1'b0;
                    s_d.busy   = 1'b1;
                    s_d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (s_q.gap == GAP_W'(GAP_TICKS)) begin
                    s_d.cs_n    = 1'b0;
                    s_d.sck     = 1'b0;
                    s_d.tx      = frame_word;
                    s_d.rx      = '0;
                    s_d.bit_cnt = '0;
                    s_d.gap     = '0;
                    div_clr     = 1'b1;
                    s_d.st      = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!s_q.sck) begin
                        s_d.sck = 1'b1;
                        s_d.rx  = {s_q.rx[FRAME_W-2:0], spi_miso};
                    end else begin
                        s_d.sck     = 1'b0;
                        s_d.tx      = {s_q.tx[FRAME_W-2:0], 1'b0};
                        s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                        if (s_q.bit_cnt == CNT_W'(FRAME_W - 1)) begin
                            s_d.cs_n = 1'b1;
                            if (!s_q.phase && s_q.any_rd) begin
                                s_d.phase = 1'b1;
                                s_d.st    = ST_WAIT;
                            end else begin
                                s_d.st   = ST_IDLE;
                                s_d.busy = 1'b0;
                                s_d.done = 1'b1;
                                s_d.vld  = chk_vld;
                                s_d.err  = chk_err;
                                s_d.data = chk_data;
                            end
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.cs_n <= 1'b1;
            s_q.gap  <= GAP_W'(GAP_TICKS);
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign rd_valid = s_q.vld;
    assign rd_err   = s_q.err;
    assign rd_data  = s_q.data;
    assign spi_cs_n = s_q.cs_n;
    assign spi_sck  = s_q.sck;
    assign spi_mosi = s_q.cs_n ? 1'b0 : s_q.tx[FRAME_W-1];

endmodule

// File: rtl/dch_chain_host_chk.sv
module dch_chain_host_chk #(
    parameter int N_DEV    = 3,
    parameter int HALF_DIV = 2,
    parameter int GAP_SCK  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               spi_cs_n,
    input logic               spi_sck,
    input logic [N_DEV-1:0]   rd_valid,
    input logic [N_DEV-1:0]   rd_err,
    input logic [8*N_DEV-1:0] rd_data
);
    localparam int FRAME_BITS = 16 * N_DEV;
    localparam int MIN_HI     = 2 * GAP_SCK * HALF_DIV;
    localparam int RW         = $clog2(FRAME_BITS + 1);
    localparam int HW         = $clog2(MIN_HI + 1);

    logic [RW-1:0] rise_cnt;
    logic [HW-1:0] hi_cnt;
    logic          sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            hi_cnt   <= HW'(MIN_HI);
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= spi_sck;
            if (spi_cs_n) begin
                rise_cnt <= '0;
                if (hi_cnt != HW'(MIN_HI)) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
                if (spi_sck && !sck_prev) rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // R1: bit count per frame
    p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (rise_cnt == RW'(FRAME_BITS)));

    // R1: clock parked low while deselected
    p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R8: deselect gap
    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= HW'(MIN_HI)));

    // R7: link only active inside a request
    p_cs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    // R9: completion pulse coincides with busy falling
    p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R6: flags exclusive
    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid & rd_err) == '0);

    // R9: results hold between completions
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rd_valid) && $stable(rd_err) && $stable(rd_data)));

endmodule

bind dch_chain_host dch_chain_host_chk #(
    .N_DEV    (N_DEV),
    .HALF_DIV (HALF_DIV),
    .GAP_SCK  (GAP_SCK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .rd_valid (rd_valid),
    .rd_err   (rd_err),
    .rd_data  (rd_data)
);

// File: tb/dch_chain_host_bench.sv
module dch_chain_host_bench;
    localparam int N   = 3;
    localparam int HD  = 2;
    localparam int GS  = 2;
    localparam int FW  = 16 * N;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [2*N-1:0]   req_op = '0;
    logic [5*N-1:0]   req_addr = '0;
    logic [8*N-1:0]   req_wdata = '0;
    logic             busy, done;
    logic [N-1:0]     rd_valid, rd_err;
    logic [8*N-1:0]   rd_data;
    logic             spi_cs_n, spi_sck, spi_mosi, spi_miso;

    always #4 clk = ~clk;

    dch_chain_host #(.N_DEV(N), .HALF_DIV(HD), .GAP_SCK(GS)) u_dch_chain_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_total = 0;
    int n_fail  = 0;
    bit reported = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        end
    endtask

    // ---------------- device chain model ----------------
    logic [FW-1:0] chain = '0;
    logic [7:0]    sl_mem [N][32];
    logic [N-1:0]  corrupt = '0;
    assign spi_miso = chain[FW-1];

    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            logic [FW-1:0] nxt;
            nxt = chain;
            for (int k = 0; k < N; k++) begin
                logic [15:0] u;
                u = chain[16*k +: 16];
                if (u[15:13] == 3'b010) sl_mem[k][u[12:8]] = u[7:0];
                else if (u[15:13] == 3'b001)
                    nxt[16*k +: 16] = {(corrupt[k] ? 3'b101 : 3'b111), u[12:8], sl_mem[k][u[12:8]]};
            end
            chain <= nxt;
        end else begin
            chain <= {chain[FW-2:0], spi_mosi};
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { logic v; logic e; logic [7:0] d; } res_t;
    logic [FW-1:0] exp_frames[$];
    res_t          exp_res[$];
    logic [7:0]    exp_mem [N][32];

    // frame monitor: MOSI content and length (R1, R2, R4)
    logic [FW-1:0] mon_bits = '0;
    int            mon_cnt  = 0;
    bit            frame_open = 0;
    always @(posedge spi_sck or negedge spi_cs_n or posedge spi_cs_n) begin
        if (!spi_cs_n && !spi_sck) begin
            frame_open = 1; mon_cnt = 0; mon_bits = '0;
        end else if (!spi_cs_n) begin
            mon_bits = {mon_bits[FW-2:0], spi_mosi};
            mon_cnt++;
        end else if (frame_open) begin
            frame_open = 0;
            chk(mon_cnt == FW, "R1", "sck rises per frame", 64'(mon_cnt), 64'(FW));
            if (exp_frames.size() == 0) begin
                chk(0, "R7", "unexpected frame", 64'(mon_bits), 64'(0));
            end else begin
                logic [FW-1:0] ef;
                ef = exp_frames.pop_front();
                chk(mon_bits == ef, "R2/R4", "frame bits", 64'(mon_bits), 64'(ef));
            end
        end
    end

    // result monitor (R5, R6, R9)
    always @(negedge clk) begin
        if (rst_n && done) begin
            for (int k = 0; k < N; k++) begin
                res_t r;
                if (exp_res.size() == 0) begin
                    chk(0, "R9", "done without expectation", 64'(k), 64'(0));
                end else begin
                    r = exp_res.pop_front();
                    chk(rd_valid[k] == r.v, "R6", $sformatf("rd_valid dev%0d", k), 64'(rd_valid[k]), 64'(r.v));
                    chk(rd_err[k] == r.e, "R6", $sformatf("rd_err dev%0d", k), 64'(rd_err[k]), 64'(r.e));
                    chk(rd_data[8*k +: 8] == r.d, "R5", $sformatf("rd_data dev%0d", k), 64'(rd_data[8*k +: 8]), 64'(r.d));
                end
            end
        end
    end

    // idle clock level and deselect gap (R1, R8)
    bit sck_bad = 0;
    int hi_run  = 1000;
    bit cs_prev = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n && spi_sck) sck_bad = 1;
            if (spi_cs_n) hi_run++;
            else if (cs_prev) chk(hi_run >= 2*GS*HD, "R8", "cs high gap", 64'(hi_run), 64'(2*GS*HD));
            if (!spi_cs_n) hi_run = 0;
            cs_prev = spi_cs_n;
        end
    end

    function automatic logic [FW-1:0] build_frame(logic [2*N-1:0] ops, logic [5*N-1:0] ad, logic [8*N-1:0] wd);
        logic [FW-1:0] f;
        f = '0;
        for (int d = 0; d < N; d++) begin
            case (ops[2*d +: 2])
                2'b01:   f[16*d +: 16] = {3'b010, ad[5*d +: 5], wd[8*d +: 8]};
                2'b10:   f[16*d +: 16] = {3'b001, ad[5*d +: 5], 8'h00};
                default: f[16*d +: 16] = 16'h0000;
            endcase
        end
        return f; // top slice = device N-1, sent first
    endfunction

    task automatic run_txn(input logic [2*N-1:0] ops, input logic [5*N-1:0] ad,
                           input logic [8*N-1:0] wd, input logic [N-1:0] bad, input bit inject);
        bit any_rd;
        any_rd = 0;
        while (busy) @(negedge clk);
        corrupt = bad;
        for (int d = 0; d < N; d++) if (ops[2*d +: 2] == 2'b10) any_rd = 1;
        exp_frames.push_back(build_frame(ops, ad, wd));
        if (any_rd) exp_frames.push_back('0);
        for (int d = 0; d < N; d++) begin
            res_t r;
            if (ops[2*d +: 2] == 2'b10) begin
                r.v = !bad[d]; r.e = bad[d]; r.d = exp_mem[d][ad[5*d +: 5]];
            end else begin
                r.v = 0; r.e = 0; r.d = 8'h00;
            end
            exp_res.push_back(r);
        end
        for (int d = 0; d < N; d++)
            if (ops[2*d +: 2] == 2'b01) exp_mem[d][ad[5*d +: 5]] = wd[8*d +: 8];
        req_op = ops; req_addr = ad; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R7", "busy after accept", 64'(busy), 64'(1));
        if (inject) begin
            repeat (40) @(negedge clk);
            req_op = {2'b01, 2'b01, 2'b01}; req_addr = {5'd2, 5'd2, 5'd2};
            req_wdata = {8'h99, 8'h99, 8'h99}; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy == 1'b1, "R7", "busy held during ignored request", 64'(busy), 64'(1));
        end
        do @(negedge clk); while (!done);
        chk(busy == 1'b0, "R9", "busy low with done", 64'(busy), 64'(0));
        chk(spi_cs_n == 1'b1, "R9", "cs high with done", 64'(spi_cs_n), 64'(1));
    endtask

    initial begin
        for (int k = 0; k < N; k++)
            for (int a = 0; a < 32; a++) begin
                sl_mem[k][a]  = 8'(k*37 + a*5 + 3);
                exp_mem[k][a] = 8'(k*37 + a*5 + 3);
            end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(spi_cs_n == 1'b1, "R10", "cs_n", 64'(spi_cs_n), 64'(1));
        chk(spi_sck == 1'b0, "R10", "sck", 64'(spi_sck), 64'(0));
        chk(spi_mosi == 1'b0, "R10", "mosi", 64'(spi_mosi), 64'(0));
        chk(busy == 1'b0, "R10", "busy", 64'(busy), 64'(0));
        chk(done == 1'b0, "R10", "done", 64'(done), 64'(0));
        chk(rd_valid == '0 && rd_err == '0, "R10", "flags", 64'({rd_valid, rd_err}), 64'(0));

        // R3: writes only, one frame
        run_txn({2'b01, 2'b01, 2'b01}, {5'd31, 5'd7, 5'd3}, {8'h33, 8'h22, 8'h11}, '0, 0);
        // R4/R5: read back all three
        run_txn({2'b10, 2'b10, 2'b10}, {5'd31, 5'd7, 5'd3}, '0, '0, 0);
        // mixed: read dev0, idle dev1, write dev2
        run_txn({2'b01, 2'b00, 2'b10}, {5'd0, 5'd9, 5'd0}, {8'h5A, 8'h00, 8'h00}, '0, 0);
        // R6: header corruption on dev1
        run_txn({2'b10, 2'b10, 2'b10}, {5'd0, 5'd7, 5'd31}, '0, 3'b010, 0);
        // R7: request raised while busy is ignored
        run_txn({2'b00, 2'b01, 2'b00}, {5'd0, 5'd2, 5'd0}, {8'h00, 8'hC4, 8'h00}, '0, 1);
        run_txn({2'b10, 2'b10, 2'b10}, {5'd2, 5'd2, 5'd2}, '0, '0, 0);
        // all idle: one zero frame, cleared results
        run_txn('0, '0, '0, '0, 0);
        // reserved code behaves as idle
        run_txn({2'b11, 2'b10, 2'b11}, {5'd1, 5'd7, 5'd1}, '0, '0, 0);

        repeat (300) @(negedge clk);
        chk(exp_frames.size() == 0, "R7", "all expected frames seen", 64'(exp_frames.size()), 64'(0));
        chk(exp_res.size() == 0, "R9", "all results seen", 64'(exp_res.size()), 64'(0));
        chk(!sck_bad, "R1", "sck low while deselected", 64'(sck_bad), 64'(0));
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report();
        $finish;
    end
endmodule